// File: doc/BRIEF.md
# Secure read CRC appender

This unit serves the checked-read command of a serial memory slave. A host selects the device, sends one command byte and then a 16-bit start address. If the command byte is the checked-read code, the unit fetches a fixed burst of consecutive bytes through a byte-wide memory read port and shifts them out on the serial data line, most significant bit first. Right after the last data byte it sends a 16-bit check value, so the host can verify both the address it sent and the payload it received.

The check value is accumulated bit by bit while the header is received and while the payload is shifted out. This leaves no gap between the payload and the check bytes. The serial clock, select and data-in lines are sampled in the system clock domain, and edges are detected there. The first fetch is issued as soon as the address is complete. Each later byte is prefetched while the current byte is still being sent, so the shifter never waits. Command decode for other codes, hold handling and the storage array sit outside this unit.

Timing assumptions: the serial clock stays high and low for at least 4 system clock cycles each, it is idle for at least 2 cycles around the select edges, and the memory port answers a request with `mem_rvalid` within 2 cycles.

Top module: `secure_read_crc`

## Requirements
- R1: The first byte after select is taken MSB first on rising serial clock edges. Only the code 0x13 starts a burst. For any other code, `miso_oe` stays low and `mem_req` stays low until deselect.
- R2: The two bytes after the code form the start address A, high byte first. Payload byte i comes from memory address (A + i) mod 65536.
- R3: A burst sends exactly 64 payload bytes, MSB first, followed by the 2 check bytes, high byte first.
- R4: The check value is CRC-16 with polynomial 0x1021, initial value 0xFFFF, no bit reflection and no final inversion. It covers the 2 address bytes (high byte first) followed by the 64 payload bytes.
- R5: `miso` changes only in the cycle after a sampled falling serial clock edge. The first payload bit, and the rise of `miso_oe`, come with the first falling edge after the 24th rising edge.
- R6: `miso_oe` is low in the same cycle that `cs_n` is high, and stays low while the code and address are being received.
- R7: After the last check bit, `miso` drives 0 on every further bit until deselect.
- R8: `mem_req` is a one-cycle pulse. Byte 0 is requested when the address completes. Byte n+1 is requested on the falling edge that launches the MSB of byte n. No request is made after byte 63, so a full burst makes 64 requests.
- R9: Deselecting in the middle of a burst abandons it. The next command starts with the check value back at 0xFFFF, and its output is unaffected by the abandoned burst.
- R10: Serial clock idle low (mode 0) and idle high (mode 3) give the same output stream.
- R11: After reset, `miso_oe` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` pad (low means high-Z) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 16 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 8 | Read data byte |

## Verification
The bench builds the unit with its default values: a 64-byte burst, a 16-bit address and code 0x13. With these values, one transfer covers the whole payload, both check bytes and the zero tail. A start address of 0xFFF0 makes the payload addresses wrap past 0xFFFF inside the burst. A transfer cut short after 20 payload bits, followed by a full one, exercises the abandon and fresh-start path. Both idle clock polarities are run against the same expected stream.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_STREAM,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        TX_HOLD,
        TX_LOAD_BYTE,
        TX_LOAD_WORD,
        TX_SHIFT
    } tx_op_e;

    // Serial-side events seen in the system clock domain
    typedef struct packed {
        logic sel;
        logic rise;
        logic fall;
        logic din;
    } spi_evt_t;

    // One bit of an MSB-first CRC register
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             bit_in,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = cur[CRC_W-1] ^ bit_in;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/srd_edge_sync.sv
module srd_edge_sync
    import srd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     mosi,
    output spi_evt_t evt
);
    logic cs_q;
    logic sck_q1;
    logic sck_q2;
    logic mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sck_q1 <= 1'b0;
            sck_q2 <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sck_q1 <= sck;
            sck_q2 <= sck_q1;
            mosi_q <= mosi;
        end
    end

    always_comb begin
        evt.sel  = ~cs_q;
        evt.rise = sck_q1 & ~sck_q2;
        evt.fall = ~sck_q1 & sck_q2;
        evt.din  = mosi_q;
    end

endmodule

// File: rtl/srd_crc16.sv
module srd_crc16
    import srd_pkg::*;
#(
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= INIT;
        end else if (en) begin
            crc_q <= crc_step(crc_q, din, POLY);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/srd_tx_shifter.sv
module srd_tx_shifter
    import srd_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  tx_op_e            op,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [W-1:0]      word_in,
    output logic              msb,
    output logic              nxt_msb
);
    logic [W-1:0] sr_q;
    logic [W-1:0] sr_d;

    always_comb begin
        unique case (op)
            TX_LOAD_BYTE: sr_d = {byte_in, {(W-BYTE_W){1'b0}}};
            TX_LOAD_WORD: sr_d = word_in;
            TX_SHIFT:     sr_d = {sr_q[W-2:0], 1'b0};
            default:      sr_d = sr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb     = sr_q[W-1];
    assign nxt_msb = sr_d[W-1];

endmodule

// File: rtl/secure_read_crc.sv
module secure_read_crc
    import srd_pkg::*;
#(
    parameter int                 BURST_BYTES = 64,
    parameter int                 ADDR_W      = 16,
    parameter logic [BYTE_W-1:0]  OPCODE      = 8'h13,
    parameter logic [CRC_W-1:0]   CRC_INIT    = 16'hFFFF,
    parameter logic [CRC_W-1:0]   CRC_POLY    = 16'h1021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int HDR_BITS  = BYTE_W + ADDR_W;
    localparam int DATA_BITS = BURST_BYTES * BYTE_W;
    localparam int TX_SAT    = DATA_BITS + CRC_W + 1;
    localparam int RXC_W     = $clog2(HDR_BITS + 1);
    localparam int TXC_W     = $clog2(TX_SAT + 1);
    localparam int IDX_W     = $clog2(BURST_BYTES + 1);

    localparam logic [RXC_W-1:0] OP_LAST   = RXC_W'(BYTE_W - 1);
    localparam logic [RXC_W-1:0] HDR_LAST  = RXC_W'(HDR_BITS - 1);
    localparam logic [TXC_W-1:0] DATA_END  = TXC_W'(DATA_BITS);
    localparam logic [TXC_W-1:0] SAT_VAL   = TXC_W'(TX_SAT);
    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(BURST_BYTES);

    spi_evt_t           evt;
    phase_e             phase_q;
    logic [RXC_W-1:0]   rx_cnt;
    logic [ADDR_W-2:0]  rx_sr;
    logic [ADDR_W-1:0]  rx_next;
    logic [TXC_W-1:0]   tx_cnt;
    logic [IDX_W-1:0]   byte_idx;
    logic [ADDR_W-1:0]  base_addr;
    logic [BYTE_W-1:0]  buf_q;
    logic               oe_q;
    logic               req_q;
    logic [ADDR_W-1:0]  req_addr_q;

    logic               stream_fall;
    logic               in_data;
    logic               byte_start;
    tx_op_e             tx_op;
    logic               tx_msb;
    logic               tx_nxt;
    logic               crc_clr;
    logic               crc_en;
    logic               crc_din;
    logic [CRC_W-1:0]   crc_val;

    srd_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .mosi (mosi),
        .evt  (evt)
    );

    // Receive path: header bits arrive MSB first
    assign rx_next = {rx_sr, evt.din};

    // Transmit scheduling
    assign stream_fall = evt.sel && evt.fall && (phase_q == PH_STREAM);
    assign in_data     = tx_cnt < DATA_END;
    assign byte_start  = in_data && (tx_cnt[2:0] == 3'd0);

    always_comb begin
        tx_op = TX_HOLD;
        if (stream_fall) begin
            if (byte_start) begin
                tx_op = TX_LOAD_BYTE;
            end else if (tx_cnt == DATA_END) begin
                tx_op = TX_LOAD_WORD;
            end else begin
                tx_op = TX_SHIFT;
            end
        end
    end

    srd_tx_shifter #(.W(CRC_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .op      (tx_op),
        .byte_in (buf_q),
        .word_in (crc_val),
        .msb     (tx_msb),
        .nxt_msb (tx_nxt)
    );

    // Check value: address bits on the way in, payload bits on the way out
    always_comb begin
        crc_clr = (phase_q == PH_IDLE) && evt.sel;
        crc_en  = 1'b0;
        crc_din = 1'b0;
        if (evt.sel && evt.rise && (phase_q == PH_ADDR)) begin
            crc_en  = 1'b1;
            crc_din = evt.din;
        end else if (stream_fall && in_data) begin
            crc_en  = 1'b1;
            crc_din = tx_nxt;
        end
    end

    srd_crc16 #(.INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (crc_din),
        .crc (crc_val)
    );

    // Sequencing and memory fetch
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            rx_cnt     <= '0;
            rx_sr      <= '0;
            tx_cnt     <= '0;
            byte_idx   <= '0;
            base_addr  <= '0;
            buf_q      <= '0;
            oe_q       <= 1'b0;
            req_q      <= 1'b0;
            req_addr_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (mem_rvalid) begin
                buf_q <= mem_rdata;
            end
            if (!evt.sel) begin
                phase_q <= PH_IDLE;
                oe_q    <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        phase_q  <= PH_CMD;
                        rx_cnt   <= '0;
                        tx_cnt   <= '0;
                        byte_idx <= '0;
                    end
                    PH_CMD: begin
                        if (evt.rise) begin
                            rx_sr  <= rx_next[ADDR_W-2:0];
                            rx_cnt <= rx_cnt + 1'b1;
                            if (rx_cnt == OP_LAST) begin
                                phase_q <= (rx_next[BYTE_W-1:0] == OPCODE) ? PH_ADDR : PH_SKIP;
                            end
                        end
                    end
                    PH_ADDR: begin
                        if (evt.rise) begin
                            rx_sr  <= rx_next[ADDR_W-2:0];
                            rx_cnt <= rx_cnt + 1'b1;
                            if (rx_cnt == HDR_LAST) begin
                                base_addr  <= rx_next;
                                req_q      <= 1'b1;
                                req_addr_q <= rx_next;
                                byte_idx   <= IDX_W'(1);
                                phase_q    <= PH_STREAM;
                            end
                        end
                    end
                    PH_STREAM: begin
                        if (evt.fall) begin
                            oe_q <= 1'b1;
                            if (tx_cnt != SAT_VAL) begin
                                tx_cnt <= tx_cnt + 1'b1;
                            end
                            if (byte_start && (byte_idx != IDX_END)) begin
                                req_q      <= 1'b1;
                                req_addr_q <= base_addr + ADDR_W'(byte_idx);
                                byte_idx   <= byte_idx + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso     = tx_msb;
    assign miso_oe  = oe_q & ~cs_n;
    assign mem_req  = req_q;
    assign mem_addr = req_addr_q;

endmodule

// File: rtl/srd_checker.sv
module srd_checker
    import srd_pkg::*;
#(
    parameter int               BURST_BYTES = 64,
    parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
    parameter int               TXC_W       = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             miso,
    input logic             miso_oe,
    input logic             mem_req,
    input logic             sel,
    input logic             sck_fall,
    input phase_e           phase,
    input logic [TXC_W-1:0] tx_cnt,
    input logic [CRC_W-1:0] crc_val
);
    localparam logic [TXC_W-1:0] SAT_VAL = TXC_W'(BURST_BYTES * BYTE_W + CRC_W + 1);

    // R6: pad released whenever the select line is high
    p_hiz_deselected_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !miso_oe);

    // R5: the output bit only moves after a sampled falling edge
    p_move_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso));

    // R8: requests are single-cycle pulses
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R1: fetches only follow the header of a recognised command
    p_req_only_streaming_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($past(phase) == PH_ADDR || $past(phase) == PH_STREAM));

    // R1: an unrecognised code never enables the pad
    p_skip_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !miso_oe);

    // R7: after the check bytes only zeros leave
    p_zero_tail_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STREAM && tx_cnt == SAT_VAL) |-> !miso);

    // R9: each new select starts from the initial check value
    p_crc_fresh_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && sel) |=> (crc_val == CRC_INIT));

endmodule

bind secure_read_crc srd_checker #(
    .BURST_BYTES (BURST_BYTES),
    .CRC_INIT    (CRC_INIT),
    .TXC_W       (TXC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .mem_req  (mem_req),
    .sel      (evt.sel),
    .sck_fall (evt.fall),
    .phase    (phase_q),
    .tx_cnt   (tx_cnt),
    .crc_val  (crc_val)
);

// File: tb/sim_secure_read_crc.sv
module sim_secure_read_crc;

    localparam int BURST = 64;
    localparam int HALF  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;
    int req_cnt = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    secure_read_crc u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // Memory model: answers one cycle after the request
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_val(mem_addr);
        if (mem_req) req_cnt = req_cnt + 1;
    end

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic f;
            f = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (f) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pairs observed bytes with expected ones
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o;
                logic [7:0] e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(o == e, t, "stream byte", o, e);
            end
        end
    end

    // Driver: one select period; pushes expected bytes, collects received ones
    task automatic xfer(input bit m3, input logic [7:0] op, input logic [15:0] a,
                        input int data_bits, input string oe_tag);
        logic [23:0] hdr;
        logic [15:0] c;
        logic [7:0]  acc;
        bit          valid;
        bit          hdr_quiet;
        bit          skip_quiet;
        int          nbytes;
        int          exp_req;
        hdr        = {op, a};
        valid      = (op == 8'h13);
        nbytes     = data_bits / 8;
        hdr_quiet  = 1'b1;
        skip_quiet = 1'b1;
        acc        = 8'h00;
        c = 16'hFFFF;
        c = crc_byte(c, a[15:8]);
        c = crc_byte(c, a[7:0]);
        for (int i = 0; i < BURST; i++) c = crc_byte(c, mem_val(16'(a + 16'(i))));
        if (valid) begin
            for (int i = 0; i < nbytes; i++) begin
                if (i < BURST) begin
                    exp_q.push_back(mem_val(16'(a + 16'(i))));
                    tag_q.push_back("R2 R3");
                end else if (i == BURST) begin
                    exp_q.push_back(c[15:8]);
                    tag_q.push_back("R3 R4");
                end else if (i == BURST + 1) begin
                    exp_q.push_back(c[7:0]);
                    tag_q.push_back("R3 R4");
                end else begin
                    exp_q.push_back(8'h00);
                    tag_q.push_back("R7");
                end
            end
        end
        @(negedge clk);
        req_cnt = 0;
        sck = m3;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < 24 + data_bits; k++) begin
            sck  = 1'b0;
            mosi = (k < 24) ? hdr[23 - k] : 1'b0;
            if (k == 24 && valid) check(miso_oe == 1'b0, "R5", "enable before first fall", miso_oe, 0);
            repeat (HALF) @(negedge clk);
            if (k < 24) begin
                if (miso_oe) hdr_quiet = 1'b0;
            end else if (valid) begin
                if (k == 24) check(miso_oe == 1'b1, oe_tag, "enable after first fall", miso_oe, 1);
                acc = {acc[6:0], miso};
                if (((k - 24) % 8) == 7) obs_q.push_back(acc);
            end else if (miso_oe) begin
                skip_quiet = 1'b0;
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        if (!m3) begin
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        check(hdr_quiet, "R6", "pad released during header", !hdr_quiet, 0);
        cs_n = 1'b1;
        #1;
        check(miso_oe == 1'b0, "R6", "pad released at deselect", miso_oe, 0);
        repeat (4 * HALF) @(negedge clk);
        if (valid) begin
            exp_req = 1 + (data_bits + 7) / 8;
            if (exp_req > BURST) exp_req = BURST;
        end else begin
            exp_req = 0;
            check(skip_quiet, "R1", "pad stays off for other code", !skip_quiet, 0);
        end
        check(req_cnt == exp_req, valid ? "R8" : "R1", "request count", req_cnt, exp_req);
        check(exp_q.size() == 0 && obs_q.size() == 0, "R3", "unpaired bytes",
              obs_q.size(), exp_q.size());
        exp_q.delete();
        tag_q.delete();
        obs_q.delete();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R11: idle after reset
        check(miso_oe == 1'b0, "R11", "enable after reset", miso_oe, 0);
        check(mem_req == 1'b0, "R11", "request after reset", mem_req, 0);

        // Full burst, mode 0, plus two zero tail bytes (R2 R3 R4 R5 R7 R8)
        xfer(1'b0, 8'h13, 16'h1234, (BURST + 4) * 8, "R5");
        // Full burst, mode 3, address wraps past 0xFFFF (R10 R2)
        xfer(1'b1, 8'h13, 16'hFFF0, (BURST + 2) * 8, "R10");
        // Other code: nothing driven, nothing fetched (R1)
        xfer(1'b0, 8'h03, 16'h0040, 64, "R1");
        // Abandoned burst then a fresh full one (R9)
        xfer(1'b0, 8'h13, 16'h00FF, 20, "R9");
        xfer(1'b0, 8'h13, 16'h0000, (BURST + 2) * 8, "R9");
        // Mode 3 with a zero tail (R10 R7)
        xfer(1'b1, 8'h13, 16'h8001, (BURST + 3) * 8, "R10");

        finish_run();
    end

endmodule